// File: doc/BRIEF.md
# Serial ADC Output Slave

This block reproduces the digital side of a small serial-output converter, so a host reader can be tested against it or the converter emulated in logic. A local register supplies a parallel sample word. When the host pulls chip select low, the word is frozen and sent one bit at a time on a serial data pin. Four zero bits come first, then the sample with the most significant bit first. A separate enable output stands for the pin's three-state condition.

Chip select and the serial clock are sampled on the system clock, and edges are detected from those samples. A state machine has two states:

- **ST_DOWN** (powered down, output released).
- **ST_SHIFT** (frame in progress).

It has three transitions:

- **start**: ST_DOWN to ST_SHIFT on a chip-select falling edge.
- **complete**: ST_SHIFT to ST_DOWN on the last counted serial-clock falling edge.
- **abort**: ST_SHIFT to ST_DOWN on a chip-select rising edge.

A frame lasts RES+4 serial-clock falling edges, where RES is 8, 10 or 12. A completed frame raises a conversion-done flag. An aborted frame does not raise it.

Top module: `sser_adc_slave`

## Requirements
- R1: After reset, sdo_oe is 0, sdo is 0, pwr_down is 1 and conv_done is 0.
- R2: One system-clock cycle after a chip-select falling edge is sampled, sdo_oe is 1, pwr_down is 0 and sdo carries the first leading zero.
- R3: The frame word is four 0 bits followed by the RES-bit sample, most significant bit first. After k counted serial-clock falling edges, for k from 0 to RES+3, sdo shows bit k of that word counting from the front.
- R4: On falling edge number RES+4 (16 for the default RES=12), sdo_oe drops to 0, pwr_down rises to 1 and conv_done is set. conv_done stays set until the next chip-select falling edge.
- R5: A chip-select rising edge before falling edge number RES+4 releases sdo_oe one cycle after it is sampled, sets pwr_down and leaves conv_done at 0.
- R6: The sample is captured at the chip-select falling edge. Changes on the sample input during a frame do not alter the bits sent.
- R7: Serial-clock falling edges have no effect while chip select is high, and none after a completed frame while chip select stays low. sdo_oe, pwr_down and conv_done stay unchanged in both cases.
- R8: The bit counter restarts on every chip-select falling edge, so a frame after an aborted one sends its full word from the first leading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sample | input | RES | Parallel sample word |
| sdo | output | 1 | Serial data bit, 0 while released |
| sdo_oe | output | 1 | Data output enable, 0 stands for three-state |
| pwr_down | output | 1 | High while in ST_DOWN |
| conv_done | output | 1 | Last frame reached its full edge count |

## Verification
On every cycle, the assertions check four things:

- The output is released whenever the block is powered down or chip select has been high for two samples.
- The released data pin stays at 0.
- The first enabled bit is always a leading zero.
- The done flag rises only with chip select low and only while powered down.

The order of the bits, the exact edge count at which the frame ends, the freezing of the sample word, and the counter restart after an abort depend on the whole sequence of a frame. Only the bench's scenarios can show these.

// File: rtl/sser_adc_pkg.sv
package sser_adc_pkg;
    typedef enum logic [0:0] {
        ST_DOWN  = 1'b0,
        ST_SHIFT = 1'b1
    } sser_state_t;
endpackage

// File: rtl/sser_edge_det.sv
module sser_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic cs_fall,
    output logic cs_rise,
    output logic sclk_fall
);
    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    assign cs_fall   = cs_q & ~cs_n;
    assign cs_rise   = ~cs_q & cs_n;
    assign sclk_fall = sclk_q & ~sclk;
endmodule

// File: rtl/sser_bit_counter.sv
module sser_bit_counter #(
    parameter int FRAME = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(FRAME + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = inc && (cnt == LAST_IDX);
endmodule

// File: rtl/sser_shift_reg.sv
module sser_shift_reg #(
    parameter int RES   = 12,
    parameter int LEAD  = 4,
    parameter int FRAME = RES + LEAD
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           shift,
    input  logic [RES-1:0] din,
    output logic           msb
);
    logic [FRAME-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= {{LEAD{1'b0}}, din};
        end else if (shift) begin
            sr <= {sr[FRAME-2:0], 1'b0};
        end
    end

    assign msb = sr[FRAME-1];
endmodule

// File: rtl/sser_adc_slave.sv
module sser_adc_slave
    import sser_adc_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic [RES-1:0] sample,
    output logic           sdo,
    output logic           sdo_oe,
    output logic           pwr_down,
    output logic           conv_done
);
    localparam int LEAD  = 4;
    localparam int FRAME = RES + LEAD;

    sser_state_t state, state_nx;
    logic cs_fall, cs_rise, sclk_fall;
    logic start_go, bit_go, last_bit, shreg_msb;

    sser_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sclk_fall(sclk_fall)
    );

    assign start_go = (state == ST_DOWN) && cs_fall;
    assign bit_go   = (state == ST_SHIFT) && sclk_fall && !cs_rise;

    sser_bit_counter #(.FRAME(FRAME)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start_go),
        .inc  (bit_go),
        .last (last_bit)
    );

    sser_shift_reg #(.RES(RES), .LEAD(LEAD), .FRAME(FRAME)) u_sr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (start_go),
        .shift(bit_go),
        .din  (sample),
        .msb  (shreg_msb)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DOWN:  if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (cs_rise)       state_nx = ST_DOWN;
                else if (last_bit) state_nx = ST_DOWN;
            end
            default:  state_nx = ST_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_DOWN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_oe    <= 1'b0;
            conv_done <= 1'b0;
        end else begin
            sdo_oe <= (state_nx == ST_SHIFT);
            if (start_go) begin
                conv_done <= 1'b0;
            end else if (bit_go && last_bit) begin
                conv_done <= 1'b1;
            end
        end
    end

    assign sdo      = sdo_oe & shreg_msb;
    assign pwr_down = (state == ST_DOWN);
endmodule

// File: rtl/sser_adc_slave_chk.sv
module sser_adc_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sdo,
    input logic sdo_oe,
    input logic pwr_down,
    input logic conv_done
);
    p_release_on_cs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !sdo_oe);

    p_down_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !sdo_oe);

    p_released_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    p_first_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);

    p_done_needs_cs_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_done) |-> $past(!cs_n));

    p_done_when_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> pwr_down);
endmodule

bind sser_adc_slave sser_adc_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .pwr_down (pwr_down),
    .conv_done(conv_done)
);

// File: tb/sser_adc_slave_test.sv
`timescale 1ns/1ps
module sser_adc_slave_test;
    localparam int RES   = 12;
    localparam int FRAME = RES + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic [RES-1:0] sample = '0;
    logic sdo, sdo_oe, pwr_down, conv_done;

    typedef struct {
        logic  sdo;
        logic  oe;
        logic  pd;
        logic  done;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    sser_adc_slave #(.RES(RES)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample),
        .sdo(sdo), .sdo_oe(sdo_oe), .pwr_down(pwr_down), .conv_done(conv_done)
    );

    // Monitor: pops each expected item at a falling clock edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (sdo !== e.sdo || sdo_oe !== e.oe || pwr_down !== e.pd || conv_done !== e.done) begin
                    n_fails++;
                    $display("FAIL %s: got sdo=%b oe=%b pd=%b done=%b, expected sdo=%b oe=%b pd=%b done=%b",
                             e.tag, sdo, sdo_oe, pwr_down, conv_done, e.sdo, e.oe, e.pd, e.done);
                end
            end
        end
    end

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input logic s, input logic oe, input logic pd,
                              input logic dn, input string tag);
        exp_t e;
        e.sdo = s; e.oe = oe; e.pd = pd; e.done = dn; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic sclk_fall_edge();
        sclk = 1'b0; settle();
    endtask

    task automatic sclk_rise_edge();
        sclk = 1'b1; settle();
    endtask

    // Driver: runs a frame of nfall falling edges and queues the expected bits
    task automatic run_frame(input logic [RES-1:0] val, input int nfall,
                             input bit change_mid, input string tag);
        logic [FRAME-1:0] word;
        word = {4'b0000, val};
        sample = val;
        cs_n = 1'b0; settle();
        expect_now(1'b0, 1'b1, 1'b0, 1'b0, {tag, " R2 first zero"});
        if (change_mid) sample = ~val;
        for (int k = 1; k <= nfall; k++) begin
            sclk_fall_edge();
            if (k < FRAME)
                expect_now(word[FRAME-1-k], 1'b1, 1'b0, 1'b0, $sformatf("%s R3 bit %0d", tag, k));
            else
                expect_now(1'b0, 1'b0, 1'b1, 1'b1, {tag, " R4 frame end"});
            sclk_rise_edge();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect_now(1'b0, 1'b0, 1'b1, 1'b0, "R1 reset state");
        rst_n = 1'b1; settle();
        expect_now(1'b0, 1'b0, 1'b1, 1'b0, "R1 after reset");

        // R7: clock edges with chip select high are ignored
        sclk_fall_edge();
        expect_now(1'b0, 1'b0, 1'b1, 1'b0, "R7 sclk while cs high");
        sclk_rise_edge();

        // Full frame, alternating pattern
        run_frame(12'hA5C, FRAME, 1'b0, "frameA");
        // R7: extra falls after completion with cs still low
        sclk_fall_edge();
        expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R7 after done");
        sclk_rise_edge();
        cs_n = 1'b1; settle();
        expect_now(1'b0, 1'b0, 1'b1, 1'b1, "R4 done held after cs high");

        // R6: sample change mid-frame ignored
        run_frame(12'hFFF, FRAME, 1'b1, "frameB R6");
        cs_n = 1'b1; settle();

        // R5: early abort after 7 falls
        run_frame(12'h3C1, 7, 1'b0, "frameC");
        cs_n = 1'b1; settle();
        expect_now(1'b0, 1'b0, 1'b1, 1'b0, "R5 abort");
        sclk_fall_edge();
        expect_now(1'b0, 1'b0, 1'b1, 1'b0, "R7 sclk after abort");
        sclk_rise_edge();

        // R8: full frame after the abort restarts counting
        run_frame(12'h801, FRAME, 1'b0, "frameD R8");
        cs_n = 1'b1; settle();

        // R5: abort right after first bit
        run_frame(12'h7FE, 0, 1'b0, "frameE");
        cs_n = 1'b1; settle();
        expect_now(1'b0, 1'b0, 1'b1, 1'b0, "R5 immediate abort");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule